// File: doc/BRIEF.md
# Synthesiser Divider and Test-Mode Control

This block is the digital core of a frequency synthesiser loop. It turns a reference tick stream into a comparison pulse train by dividing by one of two ratios (512 or 1024 by default). It divides the prescaled oscillator tick stream by a 15-bit ratio to form the feedback pulse train. It also gates the phase detector's up/down commands on their way to the charge pump. Register fields choose the pump current, switch the pump or the varactor drive off, and select the test modes. A test mode can force the pump to one side, force the lock flag, or send the divided signals out on the port pins.

Both tick streams arrive as single-cycle enables in the core clock domain. All outputs are registered. The port-on vector has one bit per pin, in the order {P7, P6, P5, P4, P3, P0}, and a 1 means the pin is driven on (low impedance). The lock flag is the bit that the status readout reports.

Top module: `synth_core`

## Requirements
- R1: With the test enable low, a reference-select bit of 1 selects the short reference ratio (REF_LO_DIV) and 0 selects the long one (REF_HI_DIV). `fcomp_o` is a one-cycle pulse once per ratio reference ticks. After reset the long ratio is active.
- R2: A new reference ratio first applies at the next terminal count, so the period in progress completes at the old ratio. While the test enable is high, the ratio keeps its last normal-mode value. With the test enable low, the two upper test-select bits have no effect.
- R3: `fpd_o` pulses once per N oscillator ticks, where N is `div_ratio_i`. N=1 gives a pulse on every tick and N=0 means 32768. A new N first applies at the next terminal count.
- R4: `pump_hi_o` is `cur_hi_i` AND NOT `lock_i`, one cycle after the inputs.
- R5: `pump_off_i`=1 holds both pump commands low in every mode. `drive_off_o` follows `vdrive_off_i` one cycle later.
- R6: Outside the forced modes and with the pump enabled, `pump_up_o`/`pump_dn_o` follow `pd_up_i`/`pd_dn_i` one cycle later. `lock_flag_o` follows `lock_i`.
- R7: With the test enable high, test-select {bit2,bit1} = 00 forces down only and flag 0, and 01 forces up only and flag 1. Bit 0 and the detector pulses are ignored in both.
- R8: Outside the port test modes, `port_on_o` equals `port_bits_i` one cycle later. Bits 1:0 (P3, P0) always follow `port_bits_i`.
- R9: Test enable high with test-select 100 turns off P4..P7 (`port_on_o[5:2]`=0).
- R10: Test enable high with test-select 101 puts on P7 a square wave that toggles on each feedback terminal count (period 2N ticks, N high). P4..P6 are off.
- R11: Test enable high with test-select 11x puts the feedback pulse on P7 and the comparison pulse on P6. P4 and P5 are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_en_i | input | 1 | Reference tick enable |
| rf_en_i | input | 1 | Prescaled oscillator tick enable |
| div_ratio_i | input | RATIO_W | Feedback division ratio N |
| cur_hi_i | input | 1 | High pump current request |
| test_en_i | input | 1 | Test mode enable |
| test_sel_i | input | 3 | Test select; bit 0 also reference select |
| pump_off_i | input | 1 | Pump disable |
| vdrive_off_i | input | 1 | Varactor drive disable |
| port_bits_i | input | 6 | Port on request {P7,P6,P5,P4,P3,P0} |
| pd_up_i | input | 1 | Phase detector up command |
| pd_dn_i | input | 1 | Phase detector down command |
| lock_i | input | 1 | External lock indication |
| fcomp_o | output | 1 | Comparison pulse |
| fpd_o | output | 1 | Feedback divider pulse |
| pump_up_o | output | 1 | Pump sink (up) command |
| pump_dn_o | output | 1 | Pump source (down) command |
| pump_hi_o | output | 1 | High current select |
| drive_off_o | output | 1 | Varactor drive off |
| lock_flag_o | output | 1 | Lock flag for status |
| port_on_o | output | 6 | Port pin on enables |

## Verification
The assertions assume that every register field and detector input is sampled on the core clock, with no constraint on when it changes. They also assume that the short reference ratio is at least two, so that comparison pulses can never be adjacent. The stimulus changes fields only at the falling edge. It makes every ratio change right after an observed pulse, so the period in progress and the next one are known exactly. The tick enables are regular patterns (every cycle, every second or every third cycle), so each expected period is the ratio times the tick spacing.

// File: rtl/synth_pkg.sv
package synth_pkg;

    localparam int NPORT   = 6;
    localparam int PORT_P0 = 0;
    localparam int PORT_P3 = 1;
    localparam int PORT_P4 = 2;
    localparam int PORT_P5 = 3;
    localparam int PORT_P6 = 4;
    localparam int PORT_P7 = 5;

    typedef enum logic [2:0] {
        MODE_NORMAL,
        MODE_FORCE_SRC,
        MODE_FORCE_SNK,
        MODE_PORTS_REL,
        MODE_P7_HALF,
        MODE_ROUTE
    } mode_e;

    typedef struct packed {
        logic       cur_hi;
        logic       test_en;
        logic       pump_off;
        logic [2:0] sel;
        logic       vdrive_off;
    } ctrl_t;

    typedef struct packed {
        logic up;
        logic dn;
        logic hi;
        logic flag;
    } pump_t;

    function automatic mode_e decode_mode(input logic test_en, input logic [2:0] sel);
        mode_e m;
        if (!test_en) begin
            m = MODE_NORMAL;
        end else begin
            case (sel[2:1])
                2'b00:   m = MODE_FORCE_SRC;
                2'b01:   m = MODE_FORCE_SNK;
                2'b10:   m = sel[0] ? MODE_P7_HALF : MODE_PORTS_REL;
                default: m = MODE_ROUTE;
            endcase
        end
        return m;
    endfunction

    function automatic logic port_next(input mode_e m, input int idx, input logic req,
                                       input logic half, input logic fpd, input logic fcomp);
        logic v;
        v = req;
        if (idx >= PORT_P4 &&
            (m == MODE_PORTS_REL || m == MODE_P7_HALF || m == MODE_ROUTE))
            v = 1'b0;
        if (idx == PORT_P7 && m == MODE_P7_HALF) v = half;
        if (idx == PORT_P7 && m == MODE_ROUTE)   v = fpd;
        if (idx == PORT_P6 && m == MODE_ROUTE)   v = fcomp;
        return v;
    endfunction

endpackage

// File: rtl/synth_ref_div.sv
module synth_ref_div #(
    parameter int LO_DIV = 512,
    parameter int HI_DIV = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic test_en_i,
    input  logic sel_lo_i,
    output logic pulse_o
);
    localparam int CW = $clog2(HI_DIV);
    localparam logic [CW-1:0] LO_LAST = CW'(LO_DIV - 1);
    localparam logic [CW-1:0] HI_LAST = CW'(HI_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          sel_lo_q;
    logic          sel_lo_d;
    logic          term;

    // the ratio request is frozen while a test mode is active
    assign sel_lo_d = test_en_i ? sel_lo_q : sel_lo_i;
    assign term     = tick_i && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= HI_LAST;
            sel_lo_q <= 1'b0;
            pulse_o  <= 1'b0;
        end else begin
            sel_lo_q <= sel_lo_d;
            pulse_o  <= term;
            if (term)
                cnt_q <= sel_lo_d ? LO_LAST : HI_LAST;
            else if (tick_i)
                cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/synth_prog_div.sv
module synth_prog_div #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic [W-1:0] ratio_i,
    output logic         pulse_o,
    output logic         half_o
);
    logic [W-1:0] cnt_q;
    logic         term;

    assign term = tick_i && (cnt_q == '0);

    // a zero ratio wraps to all ones and so divides by 2**W
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= ratio_i - 1'b1;
            pulse_o <= 1'b0;
            half_o  <= 1'b0;
        end else begin
            pulse_o <= term;
            if (term) begin
                cnt_q  <= ratio_i - 1'b1;
                half_o <= ~half_o;
            end else if (tick_i) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/synth_pump_gate.sv
module synth_pump_gate
    import synth_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode_i,
    input  logic  cur_hi_i,
    input  logic  pump_off_i,
    input  logic  pd_up_i,
    input  logic  pd_dn_i,
    input  logic  lock_i,
    output pump_t pump_o
);
    pump_t nxt;

    always_comb begin
        nxt.hi = cur_hi_i & ~lock_i;
        case (mode_i)
            MODE_FORCE_SRC: begin
                nxt.up   = 1'b0;
                nxt.dn   = 1'b1;
                nxt.flag = 1'b0;
            end
            MODE_FORCE_SNK: begin
                nxt.up   = 1'b1;
                nxt.dn   = 1'b0;
                nxt.flag = 1'b1;
            end
            default: begin
                nxt.up   = pd_up_i;
                nxt.dn   = pd_dn_i;
                nxt.flag = lock_i;
            end
        endcase
        if (pump_off_i) begin
            nxt.up = 1'b0;
            nxt.dn = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pump_o <= '0;
        else     pump_o <= nxt;
    end
endmodule

// File: rtl/synth_port_mux.sv
module synth_port_mux
    import synth_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  mode_e            mode_i,
    input  logic [NPORT-1:0] bits_i,
    input  logic             half_i,
    input  logic             fpd_i,
    input  logic             fcomp_i,
    output logic [NPORT-1:0] on_o
);
    logic [NPORT-1:0] nxt_on;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign nxt_on[p] = port_next(mode_i, p, bits_i[p], half_i, fpd_i, fcomp_i);
    end

    always_ff @(posedge clk) begin
        if (rst) on_o <= '0;
        else     on_o <= nxt_on;
    end
endmodule

// File: rtl/synth_core.sv
module synth_core
    import synth_pkg::*;
#(
    parameter int REF_LO_DIV = 512,
    parameter int REF_HI_DIV = 1024,
    parameter int RATIO_W    = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_en_i,
    input  logic               rf_en_i,
    input  logic [RATIO_W-1:0] div_ratio_i,
    input  logic               cur_hi_i,
    input  logic               test_en_i,
    input  logic [2:0]         test_sel_i,
    input  logic               pump_off_i,
    input  logic               vdrive_off_i,
    input  logic [5:0]         port_bits_i,
    input  logic               pd_up_i,
    input  logic               pd_dn_i,
    input  logic               lock_i,
    output logic               fcomp_o,
    output logic               fpd_o,
    output logic               pump_up_o,
    output logic               pump_dn_o,
    output logic               pump_hi_o,
    output logic               drive_off_o,
    output logic               lock_flag_o,
    output logic [5:0]         port_on_o
);
    ctrl_t ctrl;
    mode_e mode;
    pump_t pump;
    logic  fpd_half;

    assign ctrl = '{cur_hi: cur_hi_i, test_en: test_en_i, pump_off: pump_off_i,
                    sel: test_sel_i, vdrive_off: vdrive_off_i};
    assign mode = decode_mode(ctrl.test_en, ctrl.sel);

    synth_ref_div #(.LO_DIV(REF_LO_DIV), .HI_DIV(REF_HI_DIV)) u_ref (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (ref_en_i),
        .test_en_i(ctrl.test_en),
        .sel_lo_i (ctrl.sel[0]),
        .pulse_o  (fcomp_o)
    );

    synth_prog_div #(.W(RATIO_W)) u_prog (
        .clk    (clk),
        .rst    (rst),
        .tick_i (rf_en_i),
        .ratio_i(div_ratio_i),
        .pulse_o(fpd_o),
        .half_o (fpd_half)
    );

    synth_pump_gate u_pump (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode),
        .cur_hi_i  (ctrl.cur_hi),
        .pump_off_i(ctrl.pump_off),
        .pd_up_i   (pd_up_i),
        .pd_dn_i   (pd_dn_i),
        .lock_i    (lock_i),
        .pump_o    (pump)
    );

    synth_port_mux u_ports (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode),
        .bits_i (port_bits_i),
        .half_i (fpd_half),
        .fpd_i  (fpd_o),
        .fcomp_i(fcomp_o),
        .on_o   (port_on_o)
    );

    always_ff @(posedge clk) begin
        if (rst) drive_off_o <= 1'b0;
        else     drive_off_o <= ctrl.vdrive_off;
    end

    assign pump_up_o   = pump.up;
    assign pump_dn_o   = pump.dn;
    assign pump_hi_o   = pump.hi;
    assign lock_flag_o = pump.flag;
endmodule

// File: rtl/synth_core_chk.sv
module synth_core_chk
    import synth_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ref_en_i,
    input logic       rf_en_i,
    input logic       fcomp_o,
    input logic       fpd_o,
    input logic       cur_hi_i,
    input logic       lock_i,
    input logic       pump_hi_o,
    input logic       pump_off_i,
    input logic       pump_up_o,
    input logic       pump_dn_o,
    input logic       vdrive_off_i,
    input logic       drive_off_o,
    input logic       test_en_i,
    input logic [2:0] test_sel_i,
    input logic       lock_flag_o,
    input logic [1:0] fixed_bits_i,
    input logic [5:0] port_on_o
);
    mode_e mode_now;
    logic  live_q;

    assign mode_now = decode_mode(test_en_i, test_sel_i);

    // set when the previous edge was outside reset
    always_ff @(posedge clk) live_q <= rst ? 1'b0 : 1'b1;

    assert_fcomp_single_R1: assert property (@(posedge clk) disable iff (rst)
        fcomp_o |=> !fcomp_o) else $error("comparison pulse longer than one cycle");

    assert_fcomp_tick_R1: assert property (@(posedge clk) disable iff (rst)
        (live_q && fcomp_o) |-> $past(ref_en_i)) else $error("comparison pulse without tick");

    assert_fpd_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (live_q && fpd_o) |-> $past(rf_en_i)) else $error("feedback pulse without tick");

    assert_cur_lock_R4: assert property (@(posedge clk) disable iff (rst)
        (live_q && pump_hi_o) |-> ($past(cur_hi_i) && !$past(lock_i)))
        else $error("high current while locked or not requested");

    assert_pump_off_R5: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(pump_off_i)) |-> (!pump_up_o && !pump_dn_o))
        else $error("pump active while disabled");

    assert_drive_off_R5: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (drive_off_o == $past(vdrive_off_i))) else $error("drive off mismatch");

    assert_lock_pass_R6: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(mode_now) != MODE_FORCE_SRC && $past(mode_now) != MODE_FORCE_SNK)
        |-> (lock_flag_o == $past(lock_i))) else $error("lock flag mismatch");

    assert_force_src_R7: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(mode_now) == MODE_FORCE_SRC && !$past(pump_off_i))
        |-> (pump_dn_o && !pump_up_o && !lock_flag_o)) else $error("forced source wrong");

    assert_force_snk_R7: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(mode_now) == MODE_FORCE_SNK && !$past(pump_off_i))
        |-> (pump_up_o && !pump_dn_o && lock_flag_o)) else $error("forced sink wrong");

    assert_fixed_ports_R8: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (port_on_o[1:0] == $past(fixed_bits_i))) else $error("P0/P3 mismatch");

    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(mode_now) == MODE_PORTS_REL) |-> (port_on_o[5:2] == 4'b0000))
        else $error("released ports driven");
endmodule

bind synth_core synth_core_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_en_i    (ref_en_i),
    .rf_en_i     (rf_en_i),
    .fcomp_o     (fcomp_o),
    .fpd_o       (fpd_o),
    .cur_hi_i    (cur_hi_i),
    .lock_i      (lock_i),
    .pump_hi_o   (pump_hi_o),
    .pump_off_i  (pump_off_i),
    .pump_up_o   (pump_up_o),
    .pump_dn_o   (pump_dn_o),
    .vdrive_off_i(vdrive_off_i),
    .drive_off_o (drive_off_o),
    .test_en_i   (test_en_i),
    .test_sel_i  (test_sel_i),
    .lock_flag_o (lock_flag_o),
    .fixed_bits_i(port_bits_i[1:0]),
    .port_on_o   (port_on_o)
);

// File: tb/test_synth_core.sv
module test_synth_core;
    localparam int LO = 8;
    localparam int HI = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_en_i = 1'b0;
    logic        rf_en_i = 1'b0;
    logic [14:0] div_ratio_i = 15'd5;
    logic        cur_hi_i = 1'b0;
    logic        test_en_i = 1'b0;
    logic [2:0]  test_sel_i = 3'b000;
    logic        pump_off_i = 1'b0;
    logic        vdrive_off_i = 1'b0;
    logic [5:0]  port_bits_i = 6'h00;
    logic        pd_up_i = 1'b0;
    logic        pd_dn_i = 1'b0;
    logic        lock_i = 1'b0;
    logic        fcomp_o, fpd_o, pump_up_o, pump_dn_o, pump_hi_o, drive_off_o, lock_flag_o;
    logic [5:0]  port_on_o;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 0;
    bit  ref_run = 0;
    bit  rf_run = 0;
    int  ref_div = 1;
    int  rf_div = 1;
    int  ref_ph = 0;
    int  rf_ph = 0;

    always #10 clk = ~clk;

    synth_core #(.REF_LO_DIV(LO), .REF_HI_DIV(HI), .RATIO_W(15)) i_synth_core (
        .clk(clk), .rst(rst), .ref_en_i(ref_en_i), .rf_en_i(rf_en_i),
        .div_ratio_i(div_ratio_i), .cur_hi_i(cur_hi_i), .test_en_i(test_en_i),
        .test_sel_i(test_sel_i), .pump_off_i(pump_off_i), .vdrive_off_i(vdrive_off_i),
        .port_bits_i(port_bits_i), .pd_up_i(pd_up_i), .pd_dn_i(pd_dn_i), .lock_i(lock_i),
        .fcomp_o(fcomp_o), .fpd_o(fpd_o), .pump_up_o(pump_up_o), .pump_dn_o(pump_dn_o),
        .pump_hi_o(pump_hi_o), .drive_off_o(drive_off_o), .lock_flag_o(lock_flag_o),
        .port_on_o(port_on_o)
    );

    // regular tick patterns: one tick every ref_div / rf_div cycles
    always @(negedge clk) begin
        ref_ph   <= (ref_ph + 1 >= ref_div) ? 0 : ref_ph + 1;
        rf_ph    <= (rf_ph + 1 >= rf_div) ? 0 : rf_ph + 1;
        ref_en_i <= ref_run && (ref_ph == 0);
        rf_en_i  <= rf_run && (rf_ph == 0);
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sig(input int sel);
        case (sel)
            0:       return int'(fcomp_o);
            1:       return int'(fpd_o);
            2:       return int'(port_on_o[5]);
            default: return int'(port_on_o[4]);
        endcase
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // cycles from the current sample to the next rising edge, and high samples before it
    task automatic next_rise(input int sel, output int per, output int hi);
        int prev;
        int cur;
        per  = 0;
        prev = sig(sel);
        hi   = prev;
        while (per < 40000) begin
            @(negedge clk);
            per++;
            cur = sig(sel);
            if (cur != 0 && prev == 0) break;
            if (cur != 0) hi++;
            prev = cur;
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int p;
        int h;
        int cnt;
        step(3);
        // reset state
        check("R8 reset ports", int'(port_on_o), 0);
        check("R6 reset pump", int'({pump_up_o, pump_dn_o, pump_hi_o, lock_flag_o}), 0);
        check("R1 reset pulses", int'({fcomp_o, fpd_o}), 0);
        rst = 1'b0;
        ref_run = 1;
        rf_run = 1;

        // R1 default long ratio
        next_rise(0, p, h);
        next_rise(0, p, h);
        check("R1 default ratio period", p, HI);
        check("R1 pulse width", h, 1);

        // R2 change at terminal count, R1 short ratio
        test_sel_i = 3'b001;
        next_rise(0, p, h);
        check("R2 old ratio completes", p, HI);
        next_rise(0, p, h);
        check("R1 short ratio period", p, LO);

        // R2 upper select bits ignored in normal mode
        test_sel_i = 3'b111;
        port_bits_i = 6'h2A;
        next_rise(0, p, h);
        check("R2 upper bits ignored", p, LO);
        check("R2 ports unaffected", int'(port_on_o), 'h2A);

        // R1 slower reference ticks
        ref_div = 2;
        next_rise(0, p, h);
        next_rise(0, p, h);
        check("R1 gated ticks period", p, 2 * LO);
        ref_div = 1;
        next_rise(0, p, h);
        next_rise(0, p, h);

        // R2 hold under test mode, R11 route
        test_en_i = 1'b1;
        test_sel_i = 3'b110;
        port_bits_i = 6'h3F;
        next_rise(0, p, h);
        check("R2 held ratio 1", p, LO);
        next_rise(0, p, h);
        check("R2 held ratio 2", p, LO);
        next_rise(3, p, h);
        next_rise(3, p, h);
        check("R11 P6 comparison period", p, LO);
        check("R11 P6 pulse width", h, 1);
        next_rise(2, p, h);
        next_rise(2, p, h);
        check("R11 P7 feedback period", p, 5);
        check("R11 P4/P5 off, P0/P3 on", int'(port_on_o[3:0]), 3);

        // R2 return to normal at a terminal count
        next_rise(0, p, h);
        test_en_i = 1'b0;
        test_sel_i = 3'b000;
        next_rise(0, p, h);
        check("R2 short ratio completes", p, LO);
        next_rise(0, p, h);
        check("R2 long ratio restored", p, HI);

        // R10 half-rate square wave on P7
        test_en_i = 1'b1;
        test_sel_i = 3'b101;
        next_rise(2, p, h);
        next_rise(2, p, h);
        check("R10 P7 period", p, 10);
        check("R10 P7 high time", h, 5);
        check("R10 P4..P6 off", int'(port_on_o[4:2]), 0);

        // R9 ports released
        test_sel_i = 3'b100;
        step(2);
        check("R9 P4..P7 off", int'(port_on_o), 'h03);
        test_en_i = 1'b0;
        test_sel_i = 3'b000;
        step(1);

        // R3 feedback ratios
        next_rise(1, p, h);
        next_rise(1, p, h);
        check("R3 ratio 5", p, 5);
        div_ratio_i = 15'd3;
        next_rise(1, p, h);
        check("R3 old ratio completes", p, 5);
        next_rise(1, p, h);
        check("R3 ratio 3", p, 3);
        div_ratio_i = 15'd1;
        step(8);
        cnt = 0;
        for (int i = 0; i < 6; i++) begin
            cnt += sig(1);
            step(1);
        end
        check("R3 ratio 1 every tick", cnt, 6);
        div_ratio_i = 15'd4;
        rf_div = 3;
        next_rise(1, p, h);
        next_rise(1, p, h);
        next_rise(1, p, h);
        check("R3 gated ticks period", p, 12);
        rf_div = 1;
        div_ratio_i = 15'd7;
        next_rise(1, p, h);
        next_rise(1, p, h);
        next_rise(1, p, h);
        check("R3 ratio 7", p, 7);

        // R8 exhaustive port patterns in normal mode
        for (int b = 0; b < 64; b++) begin
            port_bits_i = 6'(b);
            step(1);
            check("R8 port pattern", int'(port_on_o), b);
        end
        test_en_i = 1'b1;
        test_sel_i = 3'b010;
        port_bits_i = 6'h35;
        step(1);
        check("R8 ports in forced mode", int'(port_on_o), 'h35);
        test_en_i = 1'b0;
        test_sel_i = 3'b000;

        // R4 current select
        for (int c = 0; c < 4; c++) begin
            cur_hi_i = c[0];
            lock_i = c[1];
            step(1);
            check("R4 current select", int'(pump_hi_o), int'(c[0] && !c[1]));
        end

        // R5 / R6 pump gating and lock flag
        for (int c = 0; c < 16; c++) begin
            pd_up_i = c[0];
            pd_dn_i = c[1];
            pump_off_i = c[2];
            lock_i = c[3];
            step(1);
            check("R5/R6 up", int'(pump_up_o), int'(c[0] && !c[2]));
            check("R5/R6 down", int'(pump_dn_o), int'(c[1] && !c[2]));
            check("R6 lock flag", int'(lock_flag_o), int'(c[3]));
        end
        vdrive_off_i = 1'b1;
        step(1);
        check("R5 drive off set", int'(drive_off_o), 1);
        vdrive_off_i = 1'b0;
        step(1);
        check("R5 drive off clear", int'(drive_off_o), 0);

        // R7 forced modes
        pump_off_i = 1'b0;
        pd_up_i = 1'b1;
        pd_dn_i = 1'b0;
        test_en_i = 1'b1;
        for (int s = 0; s < 2; s++) begin
            test_sel_i = {2'b00, s[0]};
            lock_i = 1'b1;
            step(1);
            check("R7 source", int'({pump_up_o, pump_dn_o, lock_flag_o}), 'b010);
            test_sel_i = {2'b01, s[0]};
            pd_up_i = 1'b0;
            pd_dn_i = 1'b1;
            lock_i = 1'b0;
            step(1);
            check("R7 sink", int'({pump_up_o, pump_dn_o, lock_flag_o}), 'b101);
            pd_up_i = 1'b1;
            pd_dn_i = 1'b0;
        end
        pump_off_i = 1'b1;
        step(1);
        check("R5 disable over forced sink", int'({pump_up_o, pump_dn_o, lock_flag_o}), 'b001);
        pump_off_i = 1'b0;
        test_en_i = 1'b0;
        test_sel_i = 3'b000;

        // R3 zero ratio means the full count range
        next_rise(1, p, h);
        div_ratio_i = 15'd0;
        next_rise(1, p, h);
        check("R3 ratio 7 before zero", p, 7);
        next_rise(1, p, h);
        check("R3 zero ratio", p, 32768);

        done = 1;
        summary();
        $finish;
    end
endmodule